// File: doc/BRIEF.md
# Paged ROM Table-Lookup Unit

This unit carries out the table-reference step of a small 4-bit processor. When it is started, it forms a ROM address from three parts. A 7-bit page number comes from the instruction. A 3-bit pointer register D and the 4-bit accumulator select the entry within that page. The unit then reads one 10-bit word over a synchronous ROM port and spreads that word across the processor's registers. The lowest nibble goes back to the accumulator, the next nibble goes to register B, and the two top bits can optionally go to D.

A single mode flag decides whether D is rewritten. The flag has its own set and clear commands. When it is on, the top two word bits land in D[1:0] and D[2] becomes zero. When it is off, D keeps its value. D has its own load path so that it can be given a value before a lookup. A lookup takes two cycles from the accepted start to the done pulse. A new start that arrives while a lookup is in flight is dropped.

Top module: `paged_lookup`

## Requirements
- R1: In a cycle where `start` is high and no lookup is in flight, `rom_en` is high and `rom_addr` equals {`page`[6:0], D[2:0], `acc_in`[3:0]}, with the page number in the top bits. In every other cycle `rom_en` is low.
- R2: `done` is high for exactly one cycle, two clock edges after the edge that accepts a start. It is low in the cycle in between and low again in the cycle after.
- R3: In the `done` cycle, `acc_out` equals bits [3:0] and `b_out` equals bits [7:4] of the ROM word read for that lookup.
- R4: If the mode flag was 1 when the start was accepted, then in the `done` cycle `d_out` equals {1'b0, word[9:8]}.
- R5: If the mode flag was 0 when the start was accepted, then `d_out` after the lookup equals its value before the lookup.
- R6: After a clock edge where `flag_set` is high and `flag_clr` is low, `upper_mode` is 1. After any edge where `flag_clr` is high, `upper_mode` is 0, so clear wins over set.
- R7: While reset is active and right after it, `upper_mode`, `done`, `acc_out` and `b_out` are 0.
- R8: A `start` that arrives while a lookup is in flight is ignored. It produces no `rom_en`, no extra `done`, and no change to that lookup's results.
- R9: `d_load` writes `d_val` into D when no lookup is in flight. It is ignored while a lookup is in flight.
- R10: The mode a lookup uses is the flag value at the edge that accepts the start. A flag command issued during the lookup only affects later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start a lookup |
| page | input | 7 | Page number from the instruction |
| acc_in | input | 4 | Current accumulator value |
| d_load | input | 1 | Load D from `d_val` |
| d_val | input | 3 | Value for D |
| flag_set | input | 1 | Set the mode flag |
| flag_clr | input | 1 | Clear the mode flag |
| rom_en | output | 1 | ROM read enable |
| rom_addr | output | 14 | ROM read address |
| rom_data | input | 10 | ROM word, valid one cycle after `rom_en` |
| done | output | 1 | Lookup results are valid |
| acc_out | output | 4 | New accumulator value |
| b_out | output | 4 | New B value |
| d_out | output | 3 | Current D value |
| upper_mode | output | 1 | Mode flag |

## Verification
The bench builds the unit with its default widths: a 7-bit page, a 3-bit D, a 4-bit accumulator and a 10-bit word. A bench ROM fills each word with an arithmetic function of its address. At these sizes the bench sweeps every accumulator value against every D value, in both flag modes, over four pages including the all-zero and all-one pages. Every address-concatenation boundary and every split of the word into fields is therefore covered. Directed sequences then place a start, a D load and a flag change inside a lookup in flight, to cover the ignore and mode-capture rules.

// File: rtl/paged_lookup.sv
module paged_lookup #(
  parameter int PAGE_W = 7,
  parameter int PTR_W  = 3,
  parameter int ACC_W  = 4,
  parameter int WORD_W = 10
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [PAGE_W-1:0]                page,
  input  logic [ACC_W-1:0]                 acc_in,
  input  logic                             d_load,
  input  logic [PTR_W-1:0]                 d_val,
  input  logic                             flag_set,
  input  logic                             flag_clr,
  output logic                             rom_en,
  output logic [PAGE_W+PTR_W+ACC_W-1:0]    rom_addr,
  input  logic [WORD_W-1:0]                rom_data,
  output logic                             done,
  output logic [ACC_W-1:0]                 acc_out,
  output logic [ACC_W-1:0]                 b_out,
  output logic [PTR_W-1:0]                 d_out,
  output logic                             upper_mode
);

  localparam int HI_W  = WORD_W - 2*ACC_W;
  localparam int PAD_W = PTR_W - HI_W;

  logic             busy;
  logic             mode_snap;
  logic             flag_q;
  logic             done_q;
  logic [ACC_W-1:0] a_q, b_q;
  logic [PTR_W-1:0] d_q;

  wire accept = start & ~busy;

  assign rom_en     = accept;
  assign rom_addr   = {page, d_q, acc_in};
  assign done       = done_q;
  assign acc_out    = a_q;
  assign b_out      = b_q;
  assign d_out      = d_q;
  assign upper_mode = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done_q    <= 1'b0;
      mode_snap <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      busy   <= accept;
      done_q <= busy;
      if (accept) mode_snap <= flag_q;
      if (flag_clr)      flag_q <= 1'b0;
      else if (flag_set) flag_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      d_q <= '0;
    end else if (busy) begin
      a_q <= rom_data[ACC_W-1:0];
      b_q <= rom_data[2*ACC_W-1:ACC_W];
      if (mode_snap) d_q <= {{PAD_W{1'b0}}, rom_data[WORD_W-1 -: HI_W]};
    end else if (d_load) begin
      d_q <= d_val;
    end
  end

endmodule

module paged_lookup_chk #(
  parameter int PTR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             mode_snap,
  input logic             flag_set,
  input logic             flag_clr,
  input logic             rom_en,
  input logic             done,
  input logic [PTR_W-1:0] d_out,
  input logic             upper_mode
);

  AST_ROM_EN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) rom_en |-> (start && !busy)); // R1
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> (!done ##1 done)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
  AST_D_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done && mode_snap) |-> !d_out[PTR_W-1]); // R4
  AST_D_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (done && !mode_snap) |-> $stable(d_out)); // R5
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) (flag_set && !flag_clr) |=> upper_mode); // R6
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n) flag_clr |=> !upper_mode); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !rom_en); // R8

  always_comb begin
    if (!rst_n) begin
      AST_RESET_STATE: assert (!done && !upper_mode); // R7
    end
  end

endmodule

bind paged_lookup paged_lookup_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mode_snap(mode_snap),
  .flag_set(flag_set), .flag_clr(flag_clr), .rom_en(rom_en), .done(done),
  .d_out(d_out), .upper_mode(upper_mode)
);

// File: tb/paged_lookup_tb.sv
module paged_lookup_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  page = '0;
  logic [3:0]  acc_in = '0;
  logic        d_load = 1'b0;
  logic [2:0]  d_val = '0;
  logic        flag_set = 1'b0;
  logic        flag_clr = 1'b0;
  logic        rom_en;
  logic [13:0] rom_addr;
  logic [9:0]  rom_data = '0;
  logic        done;
  logic [3:0]  acc_out, b_out;
  logic [2:0]  d_out;
  logic        upper_mode;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  paged_lookup u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .page(page), .acc_in(acc_in),
    .d_load(d_load), .d_val(d_val), .flag_set(flag_set), .flag_clr(flag_clr),
    .rom_en(rom_en), .rom_addr(rom_addr), .rom_data(rom_data), .done(done),
    .acc_out(acc_out), .b_out(b_out), .d_out(d_out), .upper_mode(upper_mode)
  );

  function automatic logic [9:0] romf(input logic [13:0] a);
    return 10'((a * 14'd173) ^ (a >> 5) ^ 14'h2A5);
  endfunction

  always @(posedge clk) if (rom_en) rom_data <= romf(rom_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk);
    flag_set = m;
    flag_clr = !m;
    @(negedge clk);
    flag_set = 0;
    flag_clr = 0;
  endtask

  task automatic lookup(input logic [6:0] p, input logic [3:0] a, input logic [2:0] d, input bit m);
    logic [9:0] w;
    logic [2:0] de;
    set_mode(m);
    d_load = 1; d_val = d;
    @(negedge clk);
    d_load = 0;
    start = 1; page = p; acc_in = a;
    #1;
    chk(rom_en === 1'b1, "R1 rom_en", rom_en, 1);
    chk(rom_addr === {p, d, a}, "R1 rom_addr", rom_addr, {p, d, a});
    w = romf({p, d, a});
    de = m ? {1'b0, w[9:8]} : d;
    @(negedge clk);
    start = 0;
    chk(done === 1'b0, "R2 gap", done, 0);
    @(negedge clk);
    chk(done === 1'b1, "R2 done", done, 1);
    chk(acc_out === w[3:0], "R3 acc", acc_out, w[3:0]);
    chk(b_out === w[7:4], "R3 b", b_out, w[7:4]);
    if (m) chk(d_out === de, "R4 d", d_out, de);
    else   chk(d_out === de, "R5 d", d_out, de);
    @(negedge clk);
    chk(done === 1'b0, "R2 single", done, 0);
  endtask

  initial begin
    logic [6:0] pages [4];
    logic [9:0] w;
    pages[0] = 7'h00; pages[1] = 7'h01; pages[2] = 7'h55; pages[3] = 7'h7F;
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && upper_mode === 1'b0, "R7 reset flags", {done, upper_mode}, 0);
    chk(acc_out === 4'h0 && b_out === 4'h0, "R7 reset data", {acc_out, b_out}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(done === 1'b0 && upper_mode === 1'b0, "R7 after reset", {done, upper_mode}, 0);

    @(negedge clk); flag_set = 1; flag_clr = 1;
    @(negedge clk); flag_set = 0; flag_clr = 0;
    chk(upper_mode === 1'b0, "R6 clear wins", upper_mode, 0);
    @(negedge clk); flag_set = 1;
    @(negedge clk); flag_set = 0;
    chk(upper_mode === 1'b1, "R6 set", upper_mode, 1);
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    chk(upper_mode === 1'b0, "R6 clear", upper_mode, 0);

    @(negedge clk); d_load = 1; d_val = 3'd5;
    @(negedge clk); d_load = 0;
    chk(d_out === 3'd5, "R9 load idle", d_out, 5);
    #1 chk(rom_en === 1'b0, "R1 idle no rom_en", rom_en, 0);

    for (int pi = 0; pi < 4; pi++)
      for (int m = 0; m < 2; m++)
        for (int d = 0; d < 8; d++)
          for (int a = 0; a < 16; a++)
            lookup(pages[pi], 4'(a), 3'(d), m[0]);

    // R8, R9 and R10: start, D load and flag set all arrive during a lookup in flight
    set_mode(0);
    d_load = 1; d_val = 3'd6;
    @(negedge clk);
    d_load = 0;
    start = 1; page = 7'h2B; acc_in = 4'h9;
    w = romf({7'h2B, 3'd6, 4'h9});
    @(negedge clk);
    acc_in = 4'h3; d_load = 1; d_val = 3'd1; flag_set = 1;
    #1 chk(rom_en === 1'b0, "R8 no rom_en in flight", rom_en, 0);
    @(negedge clk);
    start = 0; d_load = 0; flag_set = 0;
    chk(done === 1'b1, "R2 done", done, 1);
    chk(acc_out === w[3:0], "R8 acc unchanged", acc_out, w[3:0]);
    chk(b_out === w[7:4], "R8 b unchanged", b_out, w[7:4]);
    chk(d_out === 3'd6, "R10 mode captured / R9 load ignored", d_out, 6);
    chk(upper_mode === 1'b1, "R10 flag updated later", upper_mode, 1);
    @(negedge clk);
    chk(done === 1'b0, "R8 no extra done", done, 0);
    @(negedge clk);
    chk(done === 1'b0, "R8 no extra done late", done, 0);

    // R10: clear during a lookup in flight with mode 1 still writes D
    lookup(7'h10, 4'h0, 3'd7, 1'b1);
    d_load = 1; d_val = 3'd7;
    @(negedge clk);
    d_load = 0;
    start = 1; page = 7'h33; acc_in = 4'hC;
    w = romf({7'h33, 3'd7, 4'hC});
    @(negedge clk);
    start = 0; flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
    chk(d_out === {1'b0, w[9:8]}, "R10 mode 1 kept", d_out, {1'b0, w[9:8]});
    chk(upper_mode === 1'b0, "R6 clear in flight", upper_mode, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule